// File: doc/BRIEF.md
# Auto-Reload Nibble-Bus Timer

This block is an 8-bit up-counting timer that sits on a narrow 4-bit register bus. Software programs a reload value one nibble at a time. It picks a count source: an internal clock divided by a power of two, or an external count pin on either edge. It then starts the timer with a run bit. Each time the counter passes its all-ones value, it reloads itself from the reload latch and raises an interrupt request that stays high until it is cleared.

Reads return the live counter value, split into low and high nibbles, while writes go to the reload latch. A write to the low nibble is only staged. The following high-nibble write commits both halves at once. If the timer is stopped at that moment, the same write also presets the counter. The external pin is brought into the clock domain through a two-flop synchronizer, and one count is taken per selected edge.

Top module: `nrt_timer`

## Requirements
- R1: After reset, all four register addresses read 0, the reload latch is 0, and `irq_out` is 0.
- R2: Address 0 is the mode register. Bits 2:0 select the prescaler ratio, bit 3 is the run bit (1 = counting), and the register reads back as written.
- R3: A write to address 1 only stages the low nibble. It changes neither the live count nor the reload latch.
- R4: A write to address 2 commits {written data, staged low nibble} to the reload latch. If the run bit is 0 in that cycle, the counter takes the same value on that edge. While the timer runs, the counter is not loaded.
- R5: When the run bit is set and the internal source is selected, the counter advances once every 2^(sel+1) clock cycles. The first advance comes 2^(sel+1) cycles after the run bit takes effect.
- R6: A count from 0xFF loads the counter from the reload latch and sets `irq_out` on the same edge. An overflow uses the latch value held before any commit in that same cycle.
- R7: `irq_out` stays high until `irq_clr` is asserted. An overflow in the same cycle as `irq_clr` leaves it set.
- R8: Address 3 holds the edge bit (bit 0: 0 = rising, 1 = falling) and the source bit (bit 1: 1 = external pin). With the external source selected, each selected edge of `ext_cnt_in` advances the counter once. A level first sampled on clock edge k changes the count on edge k+2.
- R9: With the run bit at 0, neither the prescaler nor the external pin changes the counter. The prescaler restarts from zero when counting resumes.
- R10: Address 1 reads the low nibble of the live count, address 2 reads its high nibble, and address 3 reads {2'b00, source, edge}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 low, 2 high, 3 control) |
| reg_wdata | input | 4 | Write data nibble |
| reg_rdata | output | 4 | Read data nibble for `reg_addr` |
| ext_cnt_in | input | 1 | External count pin, asynchronous |
| irq_clr | input | 1 | Clears the interrupt request |
| irq_out | output | 1 | Interrupt request flag |

## Verification
The embedded properties check the local rules on every cycle:
- an overflow reloads the counter from the latch and sets the request;
- a stopped timer keeps its count;
- a lone low-nibble write leaves the latch alone;
- a clear without an overflow drops the request;
- neither the prescaler strobe nor the edge pulse can fire on two cycles in a row.

Other behaviours are cycle-counting matters that only the bench scenarios show: the exact division ratio for each selector value, the two-cycle latency of the external pin, the effect of changing the mode while counting, and the read-back of the nibble registers. The bench covers these with a cycle-accurate model driven by directed and seeded random traffic.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      NRT_MODE = 2'd0,
      NRT_LOW  = 2'd1,
      NRT_HIGH = 2'd2,
      NRT_CTRL = 2'd3
   } nrt_addr_e;

   localparam int CTRL_EDGE_BIT = 0;
   localparam int CTRL_SRC_BIT  = 1;
   localparam int CTRL_W        = 2;
endpackage

// File: rtl/nrt_prescaler.sv
module nrt_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = 1 << SEL_W;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("nrt_prescaler: SEL_W must be 1..5");
   end

   logic [DIV_W-1:0] presc_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < DIV_W; i++) begin
         mask[i] = (i <= int'(sel));
      end
   end

   assign tick = enable && ((presc_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      presc_q <= '0;
      else if (enable) presc_q <= presc_q + 1'b1;
      else             presc_q <= '0;
   end

   // R5
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/nrt_edge_sync.sv
module nrt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nrt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   logic rise, fall;
   assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
   assign pulse = fall_sel ? fall : rise;

   // R8
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> (!pulse || (fall_sel != $past(fall_sel))));
endmodule

// File: rtl/nrt_count_core.sv
module nrt_count_core #(
   parameter int NIB_W = 4,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             lo_we,
   input  logic             hi_we,
   input  logic [NIB_W-1:0] wnib,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] count,
   output logic             irq
);
   if (CNT_W != 2 * NIB_W) begin : g_bad_width
      $error("nrt_count_core: CNT_W must be twice NIB_W");
   end

   logic [NIB_W-1:0] stage_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             step, wrap;

   assign step = run && tick;
   assign wrap = step && (cnt_q == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '0;
         reload_q <= '0;
      end else begin
         if (lo_we) stage_q  <= wnib;
         if (hi_we) reload_q <= {wnib, stage_q};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (wrap)           cnt_q <= reload_q;
      else if (step)           cnt_q <= cnt_q + 1'b1;
      else if (hi_we && !run)  cnt_q <= {wnib, stage_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (wrap)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
   end

   assign count = cnt_q;
   assign irq   = irq_q;

   // R6
   reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && count == {CNT_W{1'b1}}) |=> (count == $past(reload_q)) && irq);
   // R9
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !hi_we) |=> $stable(count));
   // R3
   low_stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && !hi_we) |=> $stable(reload_q));
   // R7
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !(run && tick && count == {CNT_W{1'b1}})) |=> !irq);
endmodule

// File: rtl/nrt_timer.sv
module nrt_timer
   import nrt_pkg::*;
#(
   parameter int NIB_W       = 4,
   parameter int MODE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [NIB_W-1:0]  reg_wdata,
   output logic [NIB_W-1:0]  reg_rdata,
   input  logic              ext_cnt_in,
   input  logic              irq_clr,
   output logic              irq_out
);
   localparam int CNT_W   = 2 * NIB_W;
   localparam int RUN_BIT = MODE_W;

   if (MODE_W + 1 > NIB_W) begin : g_bad_mode
      $error("nrt_timer: mode field and run bit must fit in one nibble");
   end
   if (NIB_W < CTRL_W) begin : g_bad_nib
      $error("nrt_timer: nibble too narrow for control register");
   end

   logic [NIB_W-1:0]  mode_q;
   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ctrl_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == NRT_MODE) mode_q <= reg_wdata & {{(NIB_W-MODE_W-1){1'b0}}, {(MODE_W+1){1'b1}}};
         if (reg_addr == NRT_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      end
   end

   logic run, use_ext, fall_sel;
   assign run      = mode_q[RUN_BIT];
   assign use_ext  = ctrl_q[CTRL_SRC_BIT];
   assign fall_sel = ctrl_q[CTRL_EDGE_BIT];

   logic int_tick, ext_pulse, tick;

   nrt_prescaler #(.SEL_W(MODE_W)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (run && !use_ext),
      .sel    (mode_q[MODE_W-1:0]),
      .tick   (int_tick)
   );

   nrt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_cnt_in),
      .fall_sel (fall_sel),
      .pulse    (ext_pulse)
   );

   assign tick = use_ext ? ext_pulse : int_tick;

   logic [CNT_W-1:0] count;

   nrt_count_core #(.NIB_W(NIB_W), .CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .tick    (tick),
      .lo_we   (reg_we && reg_addr == NRT_LOW),
      .hi_we   (reg_we && reg_addr == NRT_HIGH),
      .wnib    (reg_wdata),
      .irq_clr (irq_clr),
      .count   (count),
      .irq     (irq_out)
   );

   always_comb begin
      unique case (reg_addr)
         NRT_MODE: reg_rdata = mode_q;
         NRT_LOW:  reg_rdata = count[NIB_W-1:0];
         NRT_HIGH: reg_rdata = count[CNT_W-1:NIB_W];
         default:  reg_rdata = {{(NIB_W-CTRL_W){1'b0}}, ctrl_q};
      endcase
   end

   // R2
   mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == NRT_MODE) |=> (mode_q[MODE_W:0] == $past(reg_wdata[MODE_W:0])));
endmodule

// File: tb/nrt_timer_tb.sv
`timescale 1ns/1ps
module nrt_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [3:0] reg_wdata = 4'd0;
   logic [3:0] reg_rdata;
   logic       ext_cnt_in = 1'b0;
   logic       irq_clr = 1'b0;
   logic       irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nrt_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_cnt_in(ext_cnt_in),
      .irq_clr(irq_clr), .irq_out(irq_out)
   );

   // reference state built from the requirements
   logic [3:0] m_mode, m_stage;
   logic [1:0] m_ctrl;
   logic [7:0] m_reload, m_cnt, m_presc;
   logic       m_irq, m_s1, m_s2, m_s3;

   function automatic logic [3:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return m_mode;
         2'd1:    return m_cnt[3:0];
         2'd2:    return m_cnt[7:4];
         default: return {2'b00, m_ctrl};
      endcase
   endfunction

   function automatic logic [7:0] div_mask(input logic [2:0] s);
      return 8'((9'd2 << s) - 9'd1);
   endfunction

   task automatic model_edge();
      logic run, src, tk, wrap, hi, lo;
      logic [7:0] n_cnt;
      run  = m_mode[3];
      src  = m_ctrl[1];
      hi   = reg_we && reg_addr == 2'd2;
      lo   = reg_we && reg_addr == 2'd1;
      if (src) tk = m_ctrl[0] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
      else     tk = (m_presc & div_mask(m_mode[2:0])) == div_mask(m_mode[2:0]);
      tk   = tk && run;
      wrap = tk && m_cnt == 8'hFF;
      n_cnt = m_cnt;
      if (wrap)           n_cnt = m_reload;
      else if (tk)        n_cnt = m_cnt + 8'd1;
      else if (hi && !run) n_cnt = {reg_wdata, m_stage};
      if (wrap)         m_irq = 1'b1;
      else if (irq_clr) m_irq = 1'b0;
      m_cnt   = n_cnt;
      if (hi) m_reload = {reg_wdata, m_stage};
      if (lo) m_stage  = reg_wdata;
      m_presc = (run && !src) ? m_presc + 8'd1 : 8'd0;
      if (reg_we && reg_addr == 2'd0) m_mode = reg_wdata;
      if (reg_we && reg_addr == 2'd3) m_ctrl = reg_wdata[1:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_cnt_in;
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string addr_tag(input logic [1:0] a);
      case (a)
         2'd0:    return "R2 mode readback";
         2'd3:    return "R8 R10 control readback";
         default: return "R4 R5 R6 R8 R9 R10 count readback";
      endcase
   endfunction

   // one cycle: inputs driven after a falling edge, compared after the next
   task automatic cyc(input logic we, input logic [1:0] a, input logic [3:0] d,
                      input logic clr, input logic pin);
      reg_we = we; reg_addr = a; reg_wdata = d; irq_clr = clr; ext_cnt_in = pin;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(addr_tag(a), 8'(reg_rdata), 8'(exp_read(a)));
      check("R6 R7 irq", 8'(irq_out), 8'(m_irq));
   endtask

   task automatic rd(input logic [1:0] a);
      cyc(1'b0, a, 4'd0, 1'b0, ext_cnt_in);
   endtask

   task automatic wr(input logic [1:0] a, input logic [3:0] d);
      cyc(1'b1, a, d, 1'b0, ext_cnt_in);
   endtask

   initial begin
      m_mode = 0; m_stage = 0; m_ctrl = 0; m_reload = 0; m_cnt = 0;
      m_presc = 0; m_irq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         reg_addr = 2'(a);
         #0.1;
         check("R1 reset read", 8'(reg_rdata), 8'd0);
      end
      check("R1 reset irq", 8'(irq_out), 8'd0);

      // R3 staged low nibble does not reach the count
      wr(2'd1, 4'h5);
      rd(2'd1);
      check("R3 low staged only", 8'(reg_rdata), 8'h0);
      // R4 high write commits and presets stopped counter
      wr(2'd2, 4'hA);
      rd(2'd1); check("R4 preset low", 8'(reg_rdata), 8'h5);
      rd(2'd2); check("R4 preset high", 8'(reg_rdata), 8'hA);
      // R9 run bit clear: no counting
      wr(2'd0, 4'h0);
      repeat (8) rd(2'd1);
      check("R9 stopped count", 8'(reg_rdata), 8'h5);

      // R5 R6: preload FE, run at ratio 2, overflow after four cycles
      wr(2'd1, 4'hE);
      wr(2'd2, 4'hF);
      wr(2'd0, 4'h8);
      rd(2'd1); rd(2'd1); rd(2'd1);
      rd(2'd1);
      check("R5 R6 reload low", 8'(reg_rdata), 8'hE);
      check("R6 irq set", 8'(irq_out), 8'd1);
      wr(2'd0, 4'h0);
      repeat (3) rd(2'd2);
      check("R7 irq held", 8'(irq_out), 8'd1);
      cyc(1'b0, 2'd0, 4'd0, 1'b1, 1'b0);
      check("R7 irq cleared", 8'(irq_out), 8'd0);

      // R8 external source, rising then falling edges
      wr(2'd1, 4'h0); wr(2'd2, 4'hF);
      wr(2'd3, 4'h2); wr(2'd0, 4'h8);
      for (int i = 0; i < 40; i++) cyc(1'b0, 2'(1 + (i % 2)), 4'd0, 1'b0, (i / 3) % 2 == 1);
      wr(2'd3, 4'h3);
      for (int i = 0; i < 40; i++) cyc(1'b0, 2'(1 + (i % 2)), 4'd0, 1'b0, (i / 2) % 2 == 1);
      rd(2'd3);
      check("R8 R10 ctrl read", 8'(reg_rdata), 8'h3);

      // R5 every ratio
      wr(2'd3, 4'h0);
      for (int s = 0; s < 8; s++) begin
         wr(2'd0, 4'(8 + s));
         for (int i = 0; i < 40; i++) rd(2'(1 + (i % 2)));
      end

      // seeded random traffic against the model
      for (int i = 0; i < 6000; i++) begin
         logic we;
         logic [1:0] a;
         logic [3:0] d;
         we = ($urandom % 8) == 0;
         a  = 2'($urandom);
         d  = 4'($urandom);
         if (we && a == 2'd0 && ($urandom % 2) == 0) d[3] = 1'b1;
         cyc(we, a, d, ($urandom % 16) == 0,
             (($urandom % 3) == 0) ? ~ext_cnt_in : ext_cnt_in);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule